// File: doc/BRIEF.md
# Two-Stage Peripheral Clock Generator

This block produces the working clock for one peripheral. Each stage picks one of six input clocks (four PLL outputs and two external pins) and divides it by a programmable ratio from 1 to 256. Each stage can also invert its own output. In a two-stage build, the second stage can take the first stage's output as its input, so the two dividers act in series. The output of the last stage drives the generated clock through an output enable. Two further outputs are gated copies of the bus clock and of the peripheral register clock.

All logic runs on the register clock `clk_i`. The source clocks are sampled as levels, and each divider counts their rising edges. Every source must therefore toggle no faster than once per `clk_i` cycle. All of a stage's settings are written into a shadow register. The divider adopts the shadow only at its terminal count, so a period that is already under way always finishes cleanly. Software may write a new setting at any time.

Top module: `clkgen_periph`

## Requirements
- R1: After reset every field is zero, all four register words read zero and all three clock outputs are low.
- R2: Register word 0 is the enable word. Bit 2 is the generated-clock enable, bits 1:0 are the bus gate and bit 3 is the peripheral gate. Words 1 and 3 configure stage 0 and stage 1. In those words, bit 1 inverts the stage, bits 4:2 are the source code and bits 12:5 hold the ratio minus one. Bits outside these fields, and all of word 2, read zero and ignore writes. Read data appears one cycle after the address.
- R3: Source codes 0 to 3 select PLL clocks 0 to 3, code 4 selects external clock 1 and code 5 selects external clock 2.
- R4: With a ratio N from 2 to 256, a stage's output is high for floor(N/2) input periods and low for the remaining ones.
- R5: A ratio of 1 passes the selected input through unchanged.
- R6: In stage 1, source code 7 selects stage 0's output. The generated clock always comes from the last stage.
- R7: The inversion bit of a stage complements that stage's output.
- R8: Source code 6 in either stage, and code 7 in stage 0, give a constant low stage output. The power-save setting (code 7, ratio 256) is one such case. A stage chained to an idle stage is itself idle, and it adopts new settings at once.
- R9: A new source, ratio or inversion takes effect only at the running divider's terminal count. The period in progress completes with the old setting.
- R10: When the output enable is low, the generated clock stays low. The enable is applied only while the divided clock is low, so no high pulse is ever shortened.
- R11: The bus clock output follows the bus clock only while both bits 1:0 are set. The peripheral clock output follows the peripheral clock only while bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register and sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| pll_clk_i | input | 4 | PLL clock inputs 0 to 3 |
| ext_clk_i | input | 2 | External clock inputs 1 and 2 |
| bus_clk_i | input | 1 | Bus clock to be gated |
| per_clk_i | input | 1 | Peripheral register clock to be gated |
| gen_clk_o | output | 1 | Generated peripheral clock |
| bus_clk_o | output | 1 | Gated bus clock |
| per_clk_o | output | 1 | Gated peripheral clock |

## Verification
Two pairs of events can land in the same stretch of time: a register write can arrive while a divided period is running, and an enable clear can arrive while the generated clock is high. The bench provokes the first case by waiting for a rising edge of the generated clock and writing a new ratio partway through that high phase. It then requires the current high and low phases to keep the old lengths and the next high phase to take the new length. It provokes the second case by clearing the enable partway through a high phase. It then requires that phase to keep its full width and the output to stay low from then on.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int SEL_W   = 3;
  localparam int RATIO_W = 8;
  localparam int NSRC    = 1 << SEL_W;
  localparam int ENB_W   = 4;
  localparam int CFG_W   = RATIO_W + SEL_W + 1;

  localparam logic [SEL_W-1:0] SRC_OFF   = 3'd6;
  localparam logic [SEL_W-1:0] SRC_CHAIN = 3'd7;

  localparam int ENB_OUT = 2;
  localparam int ENB_PER = 3;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio_m1;
    logic [SEL_W-1:0]   sel;
    logic               inv;
  } stage_cfg_t;
endpackage

// File: rtl/clkgen_regs.sv
module clkgen_regs
  import clkgen_pkg::*;
#(
  parameter int NUM_STAGES = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [1:0]                   addr_i,
  input  logic [31:0]                  wdata_i,
  output logic [31:0]                  rdata_o,
  output logic [ENB_W-1:0]             enb_o,
  output stage_cfg_t [NUM_STAGES-1:0]  cfg_o
);

  // stage s lives at word 1 + 2*s
  function automatic logic [1:0] stage_addr(int s);
    return 2'(1 + 2 * s);
  endfunction

  logic [31:0] rd_next;
  logic        unused_wdata;
  assign unused_wdata = ^{wdata_i[31:CFG_W+1], wdata_i[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enb_o <= '0;
      cfg_o <= '0;
    end else if (we_i) begin
      if (addr_i == 2'd0) enb_o <= wdata_i[ENB_W-1:0];
      for (int s = 0; s < NUM_STAGES; s++) begin
        if (addr_i == stage_addr(s)) cfg_o[s] <= stage_cfg_t'(wdata_i[CFG_W:1]);
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr_i == 2'd0) rd_next[ENB_W-1:0] = enb_o;
    for (int s = 0; s < NUM_STAGES; s++) begin
      if (addr_i == stage_addr(s)) rd_next[CFG_W:1] = cfg_o[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_next;
  end

  p_enb_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd0) |=> (enb_o == $past(wdata_i[ENB_W-1:0])));

endmodule

// File: rtl/clkgen_stage.sv
module clkgen_stage
  import clkgen_pkg::*;
#(
  parameter bit CHAIN = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic            up_idle_i,
  input  stage_cfg_t      cfg_i,
  output logic            div_o,
  output logic            idle_o
);

  stage_cfg_t         act_q;
  logic [RATIO_W-1:0] cnt_q, cnt_nxt;
  logic               prev_q, raw_q;
  logic               lvl, rise, tc, ratio1, idle;
  logic [RATIO_W:0]   half;

  assign lvl    = src_i[act_q.sel];
  assign rise   = lvl & ~prev_q;
  assign ratio1 = (act_q.ratio_m1 == '0);
  assign tc     = rise && (cnt_q == act_q.ratio_m1);
  assign half   = ({1'b0, act_q.ratio_m1} + 1'b1) >> 1;
  assign cnt_nxt = tc ? '0 : cnt_q + 1'b1;
  assign idle   = (act_q.sel == SRC_OFF) ||
                  ((act_q.sel == SRC_CHAIN) && (!CHAIN || up_idle_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      cnt_q  <= '0;
      prev_q <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      if (idle) begin
        // no edges to wait for: adopt settings now, first rise is a terminal count
        act_q <= cfg_i;
        cnt_q <= cfg_i.ratio_m1;
        raw_q <= 1'b0;
      end else if (ratio1) begin
        raw_q <= lvl;
        if (rise) begin
          act_q <= cfg_i;
          cnt_q <= '0;
        end
      end else if (rise) begin
        cnt_q <= cnt_nxt;
        raw_q <= ({1'b0, cnt_nxt} < half);
        if (tc) act_q <= cfg_i;
      end
    end
  end

  assign div_o  = raw_q ^ act_q.inv;
  assign idle_o = idle;

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= act_q.ratio_m1);

  p_idle_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> !raw_q);

  p_act_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && !rise) |=> $stable(act_q));

endmodule

// File: rtl/clkgen_gate.sv
module clkgen_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div_i,
  input  logic out_en_i,
  input  logic bus_en_i,
  input  logic per_en_i,
  input  logic bus_clk_i,
  input  logic per_clk_i,
  output logic gen_clk_o,
  output logic bus_clk_o,
  output logic per_clk_o
);

  logic en_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_act_q  <= 1'b0;
      gen_clk_o <= 1'b0;
      bus_clk_o <= 1'b0;
      per_clk_o <= 1'b0;
    end else begin
      // enable follows the request only while the divided clock is low
      if (!div_i) en_act_q <= out_en_i;
      gen_clk_o <= div_i & en_act_q;
      bus_clk_o <= bus_clk_i & bus_en_i;
      per_clk_o <= per_clk_i & per_en_i;
    end
  end

  p_no_trunc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gen_clk_o) |-> !$past(div_i));

  p_bus_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_clk_o |-> $past(bus_en_i));

  p_per_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_clk_o |-> $past(per_en_i));

endmodule

// File: rtl/clkgen_periph.sv
module clkgen_periph
  import clkgen_pkg::*;
#(
  parameter int NUM_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic [3:0]  pll_clk_i,
  input  logic [1:0]  ext_clk_i,
  input  logic        bus_clk_i,
  input  logic        per_clk_i,
  output logic        gen_clk_o,
  output logic        bus_clk_o,
  output logic        per_clk_o
);

  localparam int LAST = NUM_STAGES - 1;

  logic [ENB_W-1:0]            enb;
  stage_cfg_t [NUM_STAGES-1:0] cfg;
  logic [NUM_STAGES-1:0]       stage_out, stage_idle;
  logic                        unused_idle;

  assign unused_idle = stage_idle[LAST];

  clkgen_regs #(.NUM_STAGES(NUM_STAGES)) i_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .enb_o (enb),
    .cfg_o (cfg)
  );

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    logic [NSRC-1:0] src;
    if (s == 0) begin : g_first
      assign src = {1'b0, 1'b0, ext_clk_i, pll_clk_i};
      clkgen_stage #(.CHAIN(1'b0)) i_stage (
        .clk_i, .rst_ni, .src_i(src), .up_idle_i(1'b1), .cfg_i(cfg[s]),
        .div_o(stage_out[s]), .idle_o(stage_idle[s])
      );
    end else begin : g_next
      assign src = {stage_out[s-1], 1'b0, ext_clk_i, pll_clk_i};
      clkgen_stage #(.CHAIN(1'b1)) i_stage (
        .clk_i, .rst_ni, .src_i(src), .up_idle_i(stage_idle[s-1]), .cfg_i(cfg[s]),
        .div_o(stage_out[s]), .idle_o(stage_idle[s])
      );
    end
  end

  clkgen_gate i_gate (
    .clk_i, .rst_ni,
    .div_i     (stage_out[LAST]),
    .out_en_i  (enb[ENB_OUT]),
    .bus_en_i  (&enb[1:0]),
    .per_en_i  (enb[ENB_PER]),
    .bus_clk_i, .per_clk_i, .gen_clk_o, .bus_clk_o, .per_clk_o
  );

endmodule

// File: tb/test_clkgen_periph.sv
module test_clkgen_periph;
  localparam int TMO = 12000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        gen, bclk, pclk;

  // bench sources: pll0..3, ext1, ext2, bus, per
  int          hp [8] = '{2, 3, 4, 5, 7, 9, 1, 2};
  int          sc [8] = '{default: 0};
  logic [7:0]  sl = '0;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    for (int i = 0; i < 8; i++) begin
      if (sc[i] == hp[i] - 1) begin sc[i] <= 0; sl[i] <= ~sl[i]; end
      else sc[i] <= sc[i] + 1;
    end
  end

  clkgen_periph i_clkgen_periph (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pll_clk_i(sl[3:0]), .ext_clk_i(sl[5:4]),
    .bus_clk_i(sl[6]), .per_clk_i(sl[7]),
    .gen_clk_o(gen), .bus_clk_o(bclk), .per_clk_o(pclk)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int sel, int n, int inv);
    return 32'(((n - 1) << 5) | (sel << 2) | (inv << 1));
  endfunction

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic idle_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(output int hi, output int lo);
    int t = 0;
    hi = 0; lo = 0;
    while (gen && t < TMO) begin @(negedge clk); t++; end
    while (!gen && t < TMO) begin @(negedge clk); t++; end
    while (gen && t < TMO) begin @(negedge clk); hi++; t++; end
    while (!gen && t < TMO) begin @(negedge clk); lo++; t++; end
    if (t >= TMO) begin hi = -1; lo = -1; end
  endtask

  task automatic settle();
    int h, l;
    measure(h, l);
    measure(h, l);
  endtask

  task automatic count_high(ref logic sig, input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (sig) c++; end
  endtask

  task automatic run_period(string req, int exp_hi, int exp_lo);
    int h, l;
    settle();
    measure(h, l);
    chk({req, " high"}, h, exp_hi);
    chk({req, " low"}, l, exp_lo);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    int c;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reset read", int'(d), 0);
    end
    count_high(gen, 40, c);  chk("R1 gen low", c, 0);
    count_high(bclk, 10, c); chk("R1 bus low", c, 0);
    count_high(pclk, 10, c); chk("R1 per low", c, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); chk("R2 stage0 mask", int'(d), 32'h1FFE);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, d); chk("R2 word2 ignored", int'(d), 0);
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); chk("R2 enable mask", int'(d), 32'hF);
    wr(2'd3, mk(5, 200, 1)); rd(2'd3, d); chk("R2 stage1 fields", int'(d), int'(mk(5, 200, 1)));
    wr(2'd0, 32'h0); wr(2'd1, 32'h0); wr(2'd3, 32'h0);
  endtask

  task automatic t_even();
    wr(2'd1, mk(1, 4, 0)); wr(2'd3, mk(7, 1, 0)); wr(2'd0, 32'h4);
    run_period("R3 R4 pll1 div4", 12, 12);
  endtask

  task automatic t_odd();
    wr(2'd1, mk(4, 3, 0));
    run_period("R4 ext1 div3", 14, 28);
  endtask

  task automatic t_bypass();
    wr(2'd1, mk(2, 1, 0));
    run_period("R5 pll2 div1", 4, 4);
  endtask

  task automatic t_chain();
    wr(2'd1, mk(0, 2, 0)); wr(2'd3, mk(7, 3, 0));
    run_period("R6 chain 2x3", 8, 16);
  endtask

  task automatic t_invert();
    wr(2'd1, mk(3, 3, 0)); wr(2'd3, mk(7, 1, 1));
    run_period("R7 invert", 20, 10);
  endtask

  task automatic t_midwrite();
    int h, l, h2, t;
    wr(2'd1, mk(0, 8, 0)); wr(2'd3, mk(7, 1, 0));
    settle();
    t = 0;
    while (gen && t < TMO) begin @(negedge clk); t++; end
    while (!gen && t < TMO) begin @(negedge clk); t++; end
    h = 0;
    while (gen && t < TMO) begin
      @(negedge clk); h++; t++;
      if (h == 2) begin we = 1'b1; addr = 2'd1; wdata = mk(0, 2, 0); end
      if (h == 3) we = 1'b0;
    end
    l = 0;
    while (!gen && t < TMO) begin @(negedge clk); l++; t++; end
    h2 = 0;
    while (gen && t < TMO) begin @(negedge clk); h2++; t++; end
    chk("R9 old high kept", h, 16);
    chk("R9 old low kept", l, 16);
    chk("R9 new high", h2, 4);
  endtask

  task automatic t_disable();
    int h, c, t;
    wr(2'd1, mk(1, 4, 0));
    settle();
    t = 0;
    while (gen && t < TMO) begin @(negedge clk); t++; end
    while (!gen && t < TMO) begin @(negedge clk); t++; end
    h = 0;
    while (gen && t < TMO) begin
      @(negedge clk); h++; t++;
      if (h == 2) begin we = 1'b1; addr = 2'd0; wdata = 32'h0; end
      if (h == 3) we = 1'b0;
    end
    chk("R10 pulse not cut", h, 12);
    count_high(gen, 200, c);
    chk("R10 held low", c, 0);
    wr(2'd0, 32'h4);
    run_period("R10 re-enabled", 12, 12);
  endtask

  task automatic t_off_codes();
    int c;
    wr(2'd1, mk(6, 2, 0)); wr(2'd3, mk(7, 1, 0));
    idle_cyc(100);
    count_high(gen, 300, c); chk("R8 stage0 code6", c, 0);
    wr(2'd1, mk(0, 2, 0)); wr(2'd3, mk(6, 4, 0));
    idle_cyc(100);
    count_high(gen, 300, c); chk("R8 stage1 code6", c, 0);
  endtask

  task automatic t_powersave();
    int c;
    wr(2'd1, mk(7, 256, 0)); wr(2'd3, mk(7, 1, 0));
    idle_cyc(200);
    count_high(gen, 400, c); chk("R8 power save low", c, 0);
    wr(2'd3, mk(5, 2, 0));
    run_period("R8 R3 reload after idle chain ext2", 18, 18);
  endtask

  task automatic t_gates();
    int c;
    wr(2'd0, 32'hB);
    idle_cyc(60);
    count_high(bclk, 20, c); chk("R11 bus on", c, 10);
    count_high(pclk, 20, c); chk("R11 per on", c, 10);
    count_high(gen, 40, c);  chk("R10 gen off", c, 0);
    wr(2'd0, 32'h1);
    idle_cyc(2);
    count_high(bclk, 20, c); chk("R11 bus half gate", c, 0);
    count_high(pclk, 20, c); chk("R11 per off", c, 0);
    wr(2'd0, 32'h2);
    idle_cyc(2);
    count_high(bclk, 20, c); chk("R11 bus other half", c, 0);
  endtask

  initial begin
    idle_cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_even();
    t_odd();
    t_bypass();
    t_chain();
    t_invert();
    t_midwrite();
    t_disable();
    t_off_codes();
    t_powersave();
    t_gates();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule